// File: doc/BRIEF.md
# Conditional Instruction Decoder

The block is a purely combinational control unit for a small 32-bit load/store core. It takes one instruction word and the current four status flags (negative, zero, overflow, carry). It returns every control line the datapath needs for that instruction: the register, memory and flag write strobes, the ALU operation code, the operand-2 shifter mode, the load-data mux select, a link marker, and the two selects on the program-counter and write-back path.

Decoding has two stages. First, the condition field is tested against the flags to give an execute-enable. Then the instruction class is decoded into the control lines. Every control line starts from a safe default in which nothing is written. A failed condition leaves those defaults in place, so a skipped instruction cannot disturb any state.

The spare class code is reused for multiply. The parameter `MUL_EN` selects whether that class decodes as multiply or as an unused encoding that writes nothing.

Top module: `acd_decoder`

## Requirements
- R1: `cond_pass_o` follows instr[31:28] and nzvc_i (bit3 N, bit2 Z, bit1 V, bit0 C). The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always; 15 never.
- R2: When `cond_pass_o` is 0, `reg_we_o`, `mem_we_o` and `flag_we_o` are all 0, and every other output holds its default: `sel_a_o`=0, `sel_b_o`=1, `mem_to_reg_o`=0, `link_o`=0, `alu_op_o`=0, `shift_mode_o`=0.
- R3: The instruction class is taken from instr[27:26]: 00 data processing, 01 memory, 10 branch, 11 multiply.
- R4: For every class other than branch, `sel_a_o`=0 (next PC is PC+1) and `sel_b_o`=1 (write-back data comes from the ALU or memory).
- R5: For data processing, the command instr[24:21] maps to `alu_op_o`. Codes 0–7 and 12–15 pass through unchanged; 8→0, 9→1, 10→2 and 11→4. `reg_we_o` is 1 except for commands 8–11, which never write Rd.
- R6: `flag_we_o` equals instr[20] for data processing and multiply, and is 0 for memory and branch.
- R7: The data-processing shifter mode is 0 when instr[25]=1. When instr[25]=0 and instr[4]=0 it is 1+instr[6:5]. When instr[25]=0 and instr[4]=1 it is 5+instr[6:5].
- R8: A memory instruction with instr[20]=1 (load) gives `reg_we_o`=1, `mem_to_reg_o`=1 and `mem_we_o`=0. A store gives `mem_we_o`=1 and `reg_we_o`=0. `alu_op_o` is 4 (add) when instr[23]=1 and 2 (subtract) when it is 0. The shifter mode is 9 when instr[25]=0, and 1+instr[6:5] when instr[25]=1.
- R9: A branch gives `sel_a_o`=1, `alu_op_o`=4 and `shift_mode_o`=10. With instr[24]=1 (link) it gives `reg_we_o`=1, `sel_b_o`=0 and `link_o`=1. Without link it gives `reg_we_o`=0, `sel_b_o`=1 and `link_o`=0.
- R10: With `MUL_EN`=1, class 11 gives `reg_we_o`=1, `alu_op_o`=8 and `shift_mode_o`=11.
- R11: With `MUL_EN`=0, class 11 writes nothing: `reg_we_o`, `mem_we_o` and `flag_we_o` are all 0.
- R12: `reg_we_o` and `mem_we_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| nzvc_i | input | 4 | Current flags N,Z,V,C (bit 3 down to bit 0) |
| cond_pass_o | output | 1 | Condition field satisfied |
| reg_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 1 | Data memory write enable |
| flag_we_o | output | 1 | Flag register write enable |
| mem_to_reg_o | output | 1 | Write-back takes load data |
| link_o | output | 1 | Write-back targets the link register |
| sel_a_o | output | 1 | Next PC: 0 = PC+1, 1 = ALU result |
| sel_b_o | output | 1 | Write-back: 1 = ALU/memory, 0 = PC+1 |
| alu_op_o | output | 4 | ALU operation code |
| shift_mode_o | output | 4 | Operand-2 shifter mode |

## Verification
The bench builds two copies of the block, one with `MUL_EN`=1 and one with `MUL_EN`=0. It drives the same multiply words into both, so the reused class code and its fallback of no writes are compared side by side. All sixteen condition codes are swept against chosen flag patterns. Every data-processing command, every shifter form, both memory directions, both load and store, and both branch forms are covered, with the condition set to pass and to fail.

// File: rtl/acd_pkg.sv
package acd_pkg;
  localparam int INSTR_W = 32;
  localparam int FLAG_W  = 4;
  localparam int OP_W    = 4;
  localparam int SH_W    = 4;

  localparam logic [1:0] CLS_DP  = 2'b00;
  localparam logic [1:0] CLS_MEM = 2'b01;
  localparam logic [1:0] CLS_BR  = 2'b10;
  localparam logic [1:0] CLS_MUL = 2'b11;

  localparam logic [OP_W-1:0] ALU_AND = 4'd0;
  localparam logic [OP_W-1:0] ALU_XOR = 4'd1;
  localparam logic [OP_W-1:0] ALU_SUB = 4'd2;
  localparam logic [OP_W-1:0] ALU_ADD = 4'd4;
  localparam logic [OP_W-1:0] ALU_MUL = 4'd8;

  localparam logic [SH_W-1:0] SH_ROT_IMM = 4'd0;
  localparam logic [SH_W-1:0] SH_IMM_LSL = 4'd1;
  localparam logic [SH_W-1:0] SH_REG_LSL = 4'd5;
  localparam logic [SH_W-1:0] SH_IMM12   = 4'd9;
  localparam logic [SH_W-1:0] SH_BR24    = 4'd10;
  localparam logic [SH_W-1:0] SH_PASS    = 4'd11;
endpackage

// File: rtl/acd_cond.sv
module acd_cond
  import acd_pkg::*;
(
  input  logic [3:0]        cond_i,
  input  logic [FLAG_W-1:0] nzvc_i,
  output logic              pass_o
);
  logic n, z, v, c;
  assign {n, z, v, c} = nzvc_i;

  always_comb begin
    unique case (cond_i)
      4'd0:    pass_o = z;
      4'd1:    pass_o = !z;
      4'd2:    pass_o = c;
      4'd3:    pass_o = !c;
      4'd4:    pass_o = n;
      4'd5:    pass_o = !n;
      4'd6:    pass_o = v;
      4'd7:    pass_o = !v;
      4'd8:    pass_o = c && !z;
      4'd9:    pass_o = !c || z;
      4'd10:   pass_o = (n == v);
      4'd11:   pass_o = (n != v);
      4'd12:   pass_o = !z && (n == v);
      4'd13:   pass_o = z || (n != v);
      4'd14:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acd_dp_map.sv
module acd_dp_map
  import acd_pkg::*;
(
  input  logic [3:0]      cmd_i,
  output logic [OP_W-1:0] alu_op_o,
  output logic            wr_rd_o
);
  // compare-class commands reuse the logic ops and drop the Rd write
  always_comb begin
    wr_rd_o  = 1'b1;
    alu_op_o = cmd_i;
    unique case (cmd_i)
      4'd8:  begin alu_op_o = ALU_AND; wr_rd_o = 1'b0; end
      4'd9:  begin alu_op_o = ALU_XOR; wr_rd_o = 1'b0; end
      4'd10: begin alu_op_o = ALU_SUB; wr_rd_o = 1'b0; end
      4'd11: begin alu_op_o = ALU_ADD; wr_rd_o = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/acd_shift_sel.sv
module acd_shift_sel
  import acd_pkg::*;
(
  input  logic            imm_rot_i,
  input  logic            reg_amt_i,
  input  logic [1:0]      sh_type_i,
  output logic [SH_W-1:0] mode_o
);
  always_comb begin
    if (imm_rot_i)      mode_o = SH_ROT_IMM;
    else if (reg_amt_i) mode_o = SH_REG_LSL + SH_W'(sh_type_i);
    else                mode_o = SH_IMM_LSL + SH_W'(sh_type_i);
  end
endmodule

// File: rtl/acd_decoder.sv
module acd_decoder
  import acd_pkg::*;
#(
  parameter bit MUL_EN = 1'b1
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [FLAG_W-1:0]  nzvc_i,
  output logic               cond_pass_o,
  output logic               reg_we_o,
  output logic               mem_we_o,
  output logic               flag_we_o,
  output logic               mem_to_reg_o,
  output logic               link_o,
  output logic               sel_a_o,
  output logic               sel_b_o,
  output logic [OP_W-1:0]    alu_op_o,
  output logic [SH_W-1:0]    shift_mode_o
);
  logic [1:0]      cls;
  logic [OP_W-1:0] dp_op;
  logic            dp_wr;
  logic [SH_W-1:0] dp_sh;
  logic [SH_W-1:0] mem_sh;
  logic            mul_ok;
  logic            unused_bits;

  assign cls         = instr_i[27:26];
  assign unused_bits = ^{instr_i[22:21], instr_i[19:7], instr_i[3:0]};

  acd_cond u_cond (
    .cond_i (instr_i[31:28]),
    .nzvc_i (nzvc_i),
    .pass_o (cond_pass_o)
  );

  acd_dp_map u_dp_map (
    .cmd_i    (instr_i[24:21]),
    .alu_op_o (dp_op),
    .wr_rd_o  (dp_wr)
  );

  acd_shift_sel u_dp_sh (
    .imm_rot_i (instr_i[25]),
    .reg_amt_i (instr_i[4]),
    .sh_type_i (instr_i[6:5]),
    .mode_o    (dp_sh)
  );

  // memory offset: immediate 12-bit unless bit 25 picks a scaled register
  assign mem_sh = instr_i[25] ? (SH_IMM_LSL + SH_W'(instr_i[6:5])) : SH_IMM12;

  generate
    if (MUL_EN) begin : g_mul
      assign mul_ok = 1'b1;
    end else begin : g_no_mul
      assign mul_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    reg_we_o     = 1'b0;
    mem_we_o     = 1'b0;
    flag_we_o    = 1'b0;
    mem_to_reg_o = 1'b0;
    link_o       = 1'b0;
    sel_a_o      = 1'b0;
    sel_b_o      = 1'b1;
    alu_op_o     = '0;
    shift_mode_o = '0;
    if (cond_pass_o) begin
      unique case (cls)
        CLS_DP: begin
          reg_we_o     = dp_wr;
          flag_we_o    = instr_i[20];
          alu_op_o     = dp_op;
          shift_mode_o = dp_sh;
        end
        CLS_MEM: begin
          alu_op_o     = instr_i[23] ? ALU_ADD : ALU_SUB;
          shift_mode_o = mem_sh;
          if (instr_i[20]) begin
            reg_we_o     = 1'b1;
            mem_to_reg_o = 1'b1;
          end else begin
            mem_we_o = 1'b1;
          end
        end
        CLS_BR: begin
          sel_a_o      = 1'b1;
          alu_op_o     = ALU_ADD;
          shift_mode_o = SH_BR24;
          if (instr_i[24]) begin
            reg_we_o = 1'b1;
            sel_b_o  = 1'b0;
            link_o   = 1'b1;
          end
        end
        default: begin
          if (mul_ok) begin
            reg_we_o     = 1'b1;
            flag_we_o    = instr_i[20];
            alu_op_o     = ALU_MUL;
            shift_mode_o = SH_PASS;
          end
        end
      endcase
    end
  end

  always_comb begin
    if (!cond_pass_o)
      a_r2_no_write_on_fail: assert (!reg_we_o && !mem_we_o && !flag_we_o);
    a_r12_single_store: assert (!(reg_we_o && mem_we_o));
    if (cls != CLS_BR)
      a_r4_default_sel: assert (!sel_a_o && sel_b_o && !link_o);
    if (cls == CLS_DP && instr_i[24:23] == 2'b10)
      a_r5_compare_no_rd: assert (!reg_we_o);
    if (cls == CLS_MEM || cls == CLS_BR)
      a_r6_no_flag_write: assert (!flag_we_o);
    if (link_o)
      a_r9_link_writes: assert (reg_we_o && !sel_b_o && sel_a_o);
  end
endmodule

// File: tb/acd_decoder_tb.sv
module acd_decoder_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr;
  logic [3:0]  nzvc;
  logic        pass, rwe, mwe, fwe, m2r, lnk, sa, sb;
  logic [3:0]  aop, shm;
  logic        pass2, rwe2, mwe2, fwe2, m2r2, lnk2, sa2, sb2;
  logic [3:0]  aop2, shm2;
  int n_chk = 0, n_bad = 0;

  acd_decoder #(.MUL_EN(1'b1)) u_dut (
    .instr_i(instr), .nzvc_i(nzvc), .cond_pass_o(pass), .reg_we_o(rwe),
    .mem_we_o(mwe), .flag_we_o(fwe), .mem_to_reg_o(m2r), .link_o(lnk),
    .sel_a_o(sa), .sel_b_o(sb), .alu_op_o(aop), .shift_mode_o(shm));

  acd_decoder #(.MUL_EN(1'b0)) u_dut_nm (
    .instr_i(instr), .nzvc_i(nzvc), .cond_pass_o(pass2), .reg_we_o(rwe2),
    .mem_we_o(mwe2), .flag_we_o(fwe2), .mem_to_reg_o(m2r2), .link_o(lnk2),
    .sel_a_o(sa2), .sel_b_o(sb2), .alu_op_o(aop2), .shift_mode_o(shm2));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d instr=%h nzvc=%b", req, act, exp, instr, nzvc);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [3:0] f);
    instr = w; nzvc = f;
    #1;
  endtask

  function automatic logic [31:0] dp(input logic [3:0] c, input logic i,
      input logic [3:0] cmd, input logic s, input logic [1:0] sh, input logic r);
    return {c, 2'b00, i, cmd, s, 8'h12, 5'd3, sh, r, 4'h5};
  endfunction

  function automatic logic exp_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, v, cc;
    {n, z, v, cc} = f;
    case (c)
      0: return z;        1: return !z;
      2: return cc;       3: return !cc;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return cc & !z;  9: return !cc | z;
      10: return n == v;  11: return n != v;
      12: return !z & (n == v);
      13: return z | (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_idle;
    apply(32'hF000_0000, 4'b0000); // never-condition: all defaults
    chk("R2 rwe", rwe, 0); chk("R2 mwe", mwe, 0); chk("R2 fwe", fwe, 0);
    chk("R2 sa", sa, 0); chk("R2 sb", sb, 1); chk("R2 m2r", m2r, 0);
    chk("R2 lnk", lnk, 0); chk("R2 aop", aop, 0); chk("R2 shm", shm, 0);
  endtask

  task automatic t_cond;
    logic [3:0] fl [6] = '{4'b0000, 4'b0100, 4'b1000, 4'b1010, 4'b0011, 4'b1111};
    for (int k = 0; k < 6; k++)
      for (int c = 0; c < 16; c++) begin
        apply(dp(4'(c), 1'b1, 4'd4, 1'b1, 2'd0, 1'b0), fl[k]);
        chk("R1 cond", pass, exp_cond(4'(c), fl[k]));
        if (!exp_cond(4'(c), fl[k])) begin
          chk("R2 fail rwe", rwe, 0); chk("R2 fail fwe", fwe, 0);
        end
      end
  endtask

  task automatic t_dp;
    int eop;
    for (int c = 0; c < 16; c++) begin
      apply(dp(4'he, 1'b1, 4'(c), 1'b0, 2'd0, 1'b0), 4'b0000);
      case (c)
        8: eop = 0; 9: eop = 1; 10: eop = 2; 11: eop = 4;
        default: eop = c;
      endcase
      chk("R5 aop", aop, eop);
      chk("R5 rwe", rwe, (c >= 8 && c <= 11) ? 0 : 1);
      chk("R6 fwe S=0", fwe, 0);
      chk("R3 mwe dp", mwe, 0);
      chk("R4 sa", sa, 0); chk("R4 sb", sb, 1);
    end
    apply(dp(4'he, 1'b0, 4'd10, 1'b1, 2'd0, 1'b0), 4'b0000);
    chk("R6 fwe S=1", fwe, 1); chk("R5 cmp rwe", rwe, 0);
  endtask

  task automatic t_shift;
    apply(dp(4'he, 1'b1, 4'd13, 1'b0, 2'd2, 1'b1), 4'b0);
    chk("R7 rot imm", shm, 0);
    for (int t = 0; t < 4; t++) begin
      apply(dp(4'he, 1'b0, 4'd13, 1'b0, 2'(t), 1'b0), 4'b0);
      chk("R7 imm amt", shm, 1 + t);
      apply(dp(4'he, 1'b0, 4'd13, 1'b0, 2'(t), 1'b1), 4'b0);
      chk("R7 reg amt", shm, 5 + t);
    end
  endtask

  task automatic t_mem;
    // {cond,01,I,P,U,B,W,L,Rn,Rd,imm12}
    apply({4'he, 2'b01, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 8'h12, 12'h002}, 4'b0);
    chk("R8 ld rwe", rwe, 1); chk("R8 ld m2r", m2r, 1); chk("R8 ld mwe", mwe, 0);
    chk("R8 up add", aop, 4); chk("R8 imm12", shm, 9); chk("R6 mem fwe", fwe, 0);
    chk("R4 mem sa", sa, 0); chk("R4 mem sb", sb, 1);
    apply({4'he, 2'b01, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 8'h12, 5'd2, 2'd1, 1'b0, 4'h3}, 4'b0);
    chk("R8 st mwe", mwe, 1); chk("R8 st rwe", rwe, 0); chk("R8 st m2r", m2r, 0);
    chk("R8 down sub", aop, 2); chk("R8 reg off", shm, 2);
    apply({4'h1, 2'b01, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 8'h12, 12'h002}, 4'b0100);
    chk("R2 st fail mwe", mwe, 0);
  endtask

  task automatic t_branch;
    apply({4'h0, 2'b10, 2'b10, 24'h000006}, 4'b0101); // EQ taken, no link
    chk("R9 b sa", sa, 1); chk("R9 b rwe", rwe, 0); chk("R9 b sb", sb, 1);
    chk("R9 b lnk", lnk, 0); chk("R9 b aop", aop, 4); chk("R9 b shm", shm, 10);
    chk("R6 br fwe", fwe, 0);
    apply({4'he, 2'b10, 2'b11, 24'h000010}, 4'b0000);
    chk("R9 bl rwe", rwe, 1); chk("R9 bl sb", sb, 0); chk("R9 bl lnk", lnk, 1);
    chk("R9 bl sa", sa, 1);
    apply({4'h0, 2'b10, 2'b11, 24'h000010}, 4'b0001); // EQ not taken
    chk("R2 bl fail sa", sa, 0); chk("R2 bl fail rwe", rwe, 0);
  endtask

  task automatic t_mul;
    apply({4'he, 2'b11, 5'b00001, 1'b1, 20'h12345}, 4'b0);
    chk("R10 rwe", rwe, 1); chk("R10 aop", aop, 8); chk("R10 shm", shm, 11);
    chk("R6 mul fwe", fwe, 1); chk("R4 mul sb", sb, 1);
    chk("R11 rwe", rwe2, 0); chk("R11 mwe", mwe2, 0); chk("R11 fwe", fwe2, 0);
    chk("R3 nm pass", pass2, 1);
    apply({4'he, 2'b11, 5'b00001, 1'b0, 20'h12345}, 4'b0);
    chk("R6 mul S=0", fwe, 0);
  endtask

  task automatic t_exclusive;
    for (int c = 0; c < 4; c++) begin
      apply({4'he, 2'(c), 6'b111111, 20'hFFFFF}, 4'b0);
      chk("R12 excl", int'(rwe & mwe), 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    instr = '0; nzvc = '0;
    @(negedge clk);
    t_idle;
    t_cond;
    t_dp;
    t_shift;
    t_mem;
    t_branch;
    t_mul;
    t_exclusive;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule